// File: doc/BRIEF.md
# Multiplexed Boot ROM Read Sequencer

This block fetches data from an external parallel boot ROM through a narrow pin budget. An 8-bit bus carries the 18-bit ROM address in two pieces. It also carries the returned data. The middle address bits go out first and an external transparent latch captures them on a one-cycle strobe. The upper address bits follow in a second phase, while the ROM's chip enable (active low) is asserted. Two dedicated pins carry the lowest two address bits for the whole access.

A host command starts a read when the read control bit and the ROM select bit are both high. The command carries the address, a byte or 32-bit width choice and a wait count that sets the ROM access time. For a 32-bit read only the two dedicated low pins step, and the ROM returns four bytes. The block packs them little-endian, raises a one-cycle done flag and holds the result until the next command.

Top module: `brom_rd_seq`

## Requirements
- R1: After reset, chip_en_n is 1, bus_oe is 0, lat_stb is 0, done is 0 and busy is 0.
- R2: A read starts only when req_rd and req_rom are both 1 in the same cycle. Either one alone leaves busy at 0 and chip_en_n at 1.
- R3: The first address phase lasts 3 cycles. During it bus_oe is 1, bus_out carries address bits 9:2 and chip_en_n is 1. lat_stb is 1 only in the middle cycle of the three.
- R4: The second address phase is one cycle with bus_oe at 1, bus_out carrying address bits 17:10 and chip_en_n at 0.
- R5: From the cycle after the second phase until the data is complete, bus_oe is 0 and chip_en_n stays 0. A full cycle of release therefore comes before the first sampling window.
- R6: Each byte is sampled at the end of a window of req_wait+1 cycles. A read of n bytes raises done 6+n*(req_wait+1) cycles after the launching edge, counting the launching edge's following cycle as cycle 1.
- R7: A byte read (req_dword=0) drives address bits 1:0 on lo_addr and returns the byte in rd_data bits 7:0, with bits 31:8 equal to zero.
- R8: A dword read (req_dword=1) ignores address bits 1:0. It drives lo_addr through 0, 1, 2, 3, one value per window, and places the byte read with lo_addr=k in rd_data bits 8k+7:8k.
- R9: done is 1 for exactly one cycle, and chip_en_n is back at 1 in that cycle. rd_data keeps its value after done until another read is launched.
- R10: A command presented while busy is 1 is ignored and does not change the read in progress or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_rd | input | 1 | Read control bit of the command |
| req_rom | input | 1 | ROM select bit of the command |
| req_dword | input | 1 | 1 for a 32-bit read, 0 for a byte read |
| req_addr | input | 18 | ROM byte address |
| req_wait | input | 4 | Access wait count; each window lasts req_wait+1 cycles |
| bus_out | output | 8 | Value driven on the shared address/data bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| bus_in | input | 8 | Value read back from the shared bus |
| lat_stb | output | 1 | Strobe for the external address latch |
| lo_addr | output | 2 | Dedicated low address pins |
| chip_en_n | output | 1 | ROM chip enable, active low |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle completion flag |
| rd_data | output | 32 | Returned data, little-endian |

## Verification
The in-RTL assertions check these rules on every cycle:
- the latch strobe only occurs while the bus is driven and the ROM is deselected;
- the bus is never driven again once it has been released under an active chip enable;
- the chip enable deasserts only together with done, and done lasts a single cycle;
- the chip enable is high whenever the block is idle;
- the byte index never runs past the last lane.

Only the bench's scenarios can show the rest:
- the address fields on each phase;
- the exact latency for several wait counts;
- the little-endian packing;
- that commands arriving while busy are ignored.

The bench shows these through a behavioural latch and ROM.

// File: rtl/brom_pkg.sv
package brom_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ALO  = 3'd1,
      ST_AHI  = 3'd2,
      ST_TURN = 3'd3,
      ST_ACC  = 3'd4,
      ST_DONE = 3'd5
   } brom_state_e;
endpackage

// File: rtl/brom_seq_ctrl.sv
module brom_seq_ctrl
   import brom_pkg::*;
#(
   parameter int WAIT_W  = 4,
   parameter int LO_W    = 2,
   parameter int ALO_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dword,
   input  logic [WAIT_W-1:0] wait_cfg,
   output brom_state_e       state,
   output logic [LO_W-1:0]   idx,
   output logic              dword_q,
   output logic              sample,
   output logic              stb
);
   localparam int ALO_BITS = $clog2(ALO_CYC + 1);
   localparam int CNT_W    = (WAIT_W > ALO_BITS) ? WAIT_W : ALO_BITS;
   localparam int MID      = ALO_CYC / 2;

   generate
      if (ALO_CYC < 3 || (ALO_CYC % 2) == 0) begin : g_bad_alo
         $error("ALO_CYC must be odd and at least 3");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt;
   logic [WAIT_W-1:0] wait_q;
   logic              win_end;
   logic              last_byte;

   assign win_end   = (state == ST_ACC) && (cnt == CNT_W'(wait_q));
   assign last_byte = !dword_q || (&idx);
   assign sample    = win_end;
   assign stb       = (state == ST_ALO) && (cnt == CNT_W'(MID));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         idx     <= '0;
         dword_q <= 1'b0;
         wait_q  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state   <= ST_ALO;
                  cnt     <= '0;
                  idx     <= '0;
                  dword_q <= dword;
                  wait_q  <= wait_cfg;
               end
            end
            ST_ALO: begin
               if (cnt == CNT_W'(ALO_CYC - 1)) begin
                  state <= ST_AHI;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_AHI:  state <= ST_TURN;
            ST_TURN: begin
               state <= ST_ACC;
               cnt   <= '0;
            end
            ST_ACC: begin
               if (win_end) begin
                  cnt <= '0;
                  if (last_byte) state <= ST_DONE;
                  else           idx   <= idx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R8: the lane index never wraps inside a dword read
   a_r8_idx_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACC && $past(state) == ST_ACC) |-> (idx >= $past(idx)));
   // R6: a window never outlives the captured wait count
   a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACC) |-> (cnt <= CNT_W'(wait_q)));
endmodule

// File: rtl/brom_addr_mux.sv
module brom_addr_mux
   import brom_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int BUS_W  = 8,
   parameter int LO_W   = 2
) (
   input  brom_state_e       state,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic              dword_q,
   input  logic [LO_W-1:0]   idx,
   output logic [BUS_W-1:0]  bus_out,
   output logic              bus_oe,
   output logic [LO_W-1:0]   lo_addr,
   output logic              chip_en_n
);
   localparam int MID_LSB = LO_W;
   localparam int HI_LSB  = LO_W + BUS_W;

   logic [BUS_W-1:0] mid_part;
   logic [BUS_W-1:0] hi_part;

   assign mid_part = addr_q[MID_LSB +: BUS_W];
   assign hi_part  = addr_q[HI_LSB  +: BUS_W];

   always_comb begin
      bus_out   = '0;
      bus_oe    = 1'b0;
      chip_en_n = 1'b1;
      unique case (state)
         ST_ALO: begin
            bus_out = mid_part;
            bus_oe  = 1'b1;
         end
         ST_AHI: begin
            bus_out   = hi_part;
            bus_oe    = 1'b1;
            chip_en_n = 1'b0;
         end
         ST_TURN, ST_ACC: chip_en_n = 1'b0;
         default: ;
      endcase
   end

   assign lo_addr = dword_q ? idx : addr_q[LO_W-1:0];
endmodule

// File: rtl/brom_assembler.sv
module brom_assembler #(
   parameter int BUS_W = 8,
   parameter int LO_W  = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clear,
   input  logic                            sample,
   input  logic                            dword_q,
   input  logic [LO_W-1:0]                 idx,
   input  logic [BUS_W-1:0]                bus_in,
   output logic [BUS_W*(1<<LO_W)-1:0]      data
);
   localparam int LANES = 1 << LO_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic lane_sel;
         if (g == 0) begin : g_first
            assign lane_sel = !dword_q || (idx == LO_W'(0));
         end else begin : g_rest
            assign lane_sel = dword_q && (idx == LO_W'(g));
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    data[g*BUS_W +: BUS_W] <= '0;
            else if (clear)                data[g*BUS_W +: BUS_W] <= '0;
            else if (sample && lane_sel)   data[g*BUS_W +: BUS_W] <= bus_in;
         end
      end
   endgenerate
endmodule

// File: rtl/brom_rd_seq.sv
module brom_rd_seq
   import brom_pkg::*;
#(
   parameter int ADDR_W  = 18,
   parameter int BUS_W   = 8,
   parameter int LO_W    = 2,
   parameter int WAIT_W  = 4,
   parameter int ALO_CYC = 3,
   localparam int DATA_W = BUS_W * (1 << LO_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_rd,
   input  logic              req_rom,
   input  logic              req_dword,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WAIT_W-1:0] req_wait,
   output logic [BUS_W-1:0]  bus_out,
   output logic              bus_oe,
   input  logic [BUS_W-1:0]  bus_in,
   output logic              lat_stb,
   output logic [LO_W-1:0]   lo_addr,
   output logic              chip_en_n,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (ADDR_W != 2 * BUS_W + LO_W) begin : g_bad_addr
         $error("ADDR_W must equal two bus widths plus LO_W");
      end
      if (WAIT_W < 1) begin : g_bad_wait
         $error("WAIT_W must be at least 1");
      end
   endgenerate

   brom_state_e       state;
   logic [LO_W-1:0]   idx;
   logic              dword_q;
   logic              sample;
   logic              start;
   logic [ADDR_W-1:0] addr_q;

   assign busy  = (state != ST_IDLE);
   assign done  = (state == ST_DONE);
   assign start = req_rd && req_rom && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     addr_q <= '0;
      else if (start) addr_q <= req_addr;
   end

   brom_seq_ctrl #(.WAIT_W(WAIT_W), .LO_W(LO_W), .ALO_CYC(ALO_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .dword(req_dword),
      .wait_cfg(req_wait), .state(state), .idx(idx), .dword_q(dword_q),
      .sample(sample), .stb(lat_stb)
   );

   brom_addr_mux #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .LO_W(LO_W)) u_mux (
      .state(state), .addr_q(addr_q), .dword_q(dword_q), .idx(idx),
      .bus_out(bus_out), .bus_oe(bus_oe), .lo_addr(lo_addr),
      .chip_en_n(chip_en_n)
   );

   brom_assembler #(.BUS_W(BUS_W), .LO_W(LO_W)) u_asm (
      .clk(clk), .rst_n(rst_n), .clear(start), .sample(sample),
      .dword_q(dword_q), .idx(idx), .bus_in(bus_in), .data(rd_data)
   );

   // R3: latch strobe only with the bus driven and the ROM deselected
   a_r3_stb_on_drive: assert property (@(posedge clk) disable iff (!rst_n)
      lat_stb |-> (bus_oe && chip_en_n));
   // R5: once released under an active enable the bus stays released
   a_r5_stay_released: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_en_n && $past(!chip_en_n) && $past(!bus_oe)) |-> !bus_oe);
   // R9: the enable returns high only in the done cycle
   a_r9_ce_rise_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chip_en_n) |-> done);
   // R9: done is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2: the ROM is never selected while idle
   a_r2_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (chip_en_n && !bus_oe));
   // R9: result held between done and the next launch
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(done) && !busy) |-> $stable(rd_data));
endmodule

// File: tb/tb_brom_rd_seq.sv
module tb_brom_rd_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_rd = 1'b0, req_rom = 1'b0, req_dword = 1'b0;
   logic [17:0] req_addr = '0;
   logic [3:0]  req_wait = '0;
   logic [7:0]  bus_out, bus_in;
   logic        bus_oe, lat_stb, chip_en_n, busy, done;
   logic [1:0]  lo_addr;
   logic [31:0] rd_data;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   brom_rd_seq dut (
      .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_rom(req_rom),
      .req_dword(req_dword), .req_addr(req_addr), .req_wait(req_wait),
      .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .lat_stb(lat_stb),
      .lo_addr(lo_addr), .chip_en_n(chip_en_n), .busy(busy), .done(done),
      .rd_data(rd_data)
   );

   function automatic logic [7:0] rom_byte(input logic [17:0] a);
      return a[7:0] ^ {a[14:8], a[15]} ^ {a[17:16], 6'h2B};
   endfunction

   // behavioural latch and ROM
   logic [7:0] mid_lat = '0, hi_lat = '0;
   always @(posedge clk) begin
      if (lat_stb) mid_lat <= bus_out;
      if (!chip_en_n && bus_oe) hi_lat <= bus_out;
   end
   assign bus_in = bus_oe ? 8'h00 : rom_byte({hi_lat, mid_lat, lo_addr});

   task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(chip_en_n && !bus_oe && !lat_stb && !done && !busy, "R1 reset state",
          {27'd0, chip_en_n, bus_oe, lat_stb, done, busy}, 32'h10);
   endtask

   task automatic t_partial();
      logic bad = 1'b0;
      req_addr = 18'h12345;
      req_rd = 1'b1; req_rom = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (busy || !chip_en_n) bad = 1'b1;
      end
      req_rd = 1'b0; req_rom = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (busy || !chip_en_n) bad = 1'b1;
      end
      req_rom = 1'b0;
      chk(!bad, "R2 partial command ignored", {31'd0, bad}, 0);
   endtask

   task automatic t_read(input logic [17:0] addr, input logic dw,
                         input logic [3:0] wt, input logic inject);
      int n = dw ? 4 : 1;
      int k = 1;
      int exp_k = 6 + n * (wt + 1);
      logic b3 = 0, b4 = 0, b5 = 0, blo = 0;
      logic [31:0] exp_d = '0, held;
      for (int j = 0; j < n; j++)
         exp_d[8*j +: 8] = dw ? rom_byte({addr[17:2], 2'(j)}) : rom_byte(addr);
      @(negedge clk);
      req_addr = addr; req_dword = dw; req_wait = wt;
      req_rd = 1'b1; req_rom = 1'b1;
      @(negedge clk);
      req_rd = 1'b0; req_rom = 1'b0;
      while (k < 300) begin
         if (k <= 3) begin
            if (!bus_oe || bus_out != addr[9:2] || !chip_en_n ||
                lat_stb != (k == 2)) b3 = 1;
         end else if (k == 4) begin
            if (!bus_oe || bus_out != addr[17:10] || chip_en_n) b4 = 1;
         end else if (!done) begin
            if (bus_oe || chip_en_n) b5 = 1;
            if (k >= 6) begin
               if (dw && lo_addr != 2'((k - 6) / (wt + 1))) blo = 1;
               if (!dw && lo_addr != addr[1:0]) blo = 1;
            end
         end
         if (done) break;
         if (inject && k == 7) begin
            req_addr = ~addr; req_dword = ~dw; req_rd = 1; req_rom = 1;
         end
         if (inject && k == 8) begin req_rd = 0; req_rom = 0; end
         @(negedge clk);
         k++;
      end
      req_rd = 0; req_rom = 0;
      chk(!b3, "R3 first address phase", {31'd0, b3}, 0);
      chk(!b4, "R4 second address phase", {31'd0, b4}, 0);
      chk(!b5, "R5 bus released with enable low", {31'd0, b5}, 0);
      chk(!blo, dw ? "R8 low pins step" : "R7 low pins from address",
          {31'd0, blo}, 0);
      chk(k == exp_k, "R6 latency to done", k, exp_k);
      chk(rd_data == exp_d, inject ? "R10 busy command ignored" :
          (dw ? "R8 dword packing" : "R7 byte data"), rd_data, exp_d);
      chk(chip_en_n, "R9 enable high at done", {31'd0, chip_en_n}, 1);
      held = rd_data;
      @(negedge clk);
      @(negedge clk);
      chk(!done && rd_data == held, "R9 done one cycle, data held",
          rd_data, held);
   endtask

   initial begin
      #2_000_000;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_partial();
      t_read(18'h2A5B7, 1'b0, 4'd2, 1'b0);
      t_read(18'h00000, 1'b0, 4'd0, 1'b0);
      t_read(18'h3FFFF, 1'b1, 4'd1, 1'b0);
      t_read(18'h1C3D2, 1'b1, 4'd0, 1'b0);
      t_read(18'h05A66, 1'b0, 4'd15, 1'b0);
      t_read(18'h2F0C1, 1'b1, 4'd3, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule